// File: doc/BRIEF.md
# Cascadable Universal Up/Down Counter Stage

This block is one stage of a synchronous binary counter whose width is a parameter (six bits by default). A two-bit mode input selects one of four operations on each rising clock edge: parallel load from a preset bus, increment, decrement or hold. Counting in either direction wraps around modulo 2^W and never saturates. An asynchronous, active-high reset clears the count.

Two active-low carry inputs and two active-low carry outputs let stages be chained into a wider counter without glue logic. The carry-out is registered and marks the cycle in which the stage and everything below it sit at the terminal value. The look-ahead-carry-out marks the cycle before that one. A stage takes the look-ahead input into a flip-flop, so that flip-flop and the carry input together decide whether it advances. The lowest stage ties both carry inputs low. Each higher stage takes its carry-in from the carry-out of the stage below and its look-ahead-in from the look-ahead-out of the stage below. The whole chain then advances by one on every clock edge.

Top module: `updn_cascade_stage`

## Requirements
- R1: With mode 00, each rising clock edge loads `preset` into `count`.
- R2: With mode 01, each edge adds one to `count` modulo 2^W (all ones wraps to zero) when `cy_in_n` is low and the look-ahead flop is low.
- R3: With mode 10, each edge subtracts one from `count` modulo 2^W (zero wraps to all ones) when `cy_in_n` is low and the look-ahead flop is low.
- R4: With mode 11, `count` keeps its value. In modes 01 and 10, `count` also keeps its value on any edge where `cy_in_n` is high.
- R5: The look-ahead flop samples `la_in_n` on every edge. In modes 01 and 10, `count` keeps its value on an edge when `la_in_n` was high at the previous edge.
- R6: After each edge, `cy_out_n` is low exactly when all three hold: the mode is 01 or 10, `la_in_n` was low at that edge, and the new `count` equals the terminal value. The terminal value is all ones in mode 01 and zero in mode 10.
- R7: A load edge (mode 00) always leaves `cy_out_n` high, even when the loaded value is all ones or zero.
- R8: `la_out_n` is low only when the mode is 01 or 10 and `la_in_n` is low. If `cy_in_n` is low, `count` must also be one step short of terminal: all ones minus one in mode 01, one in mode 10. If `cy_in_n` is high, `count` must equal the terminal value.
- R9: Asserting `rst` immediately forces `count` to zero and `cy_out_n` high, and sets the look-ahead flop. Because the flop is set, the first count edge after reset leaves `count` unchanged.
- R10: Four stages chained as described form a 24-bit counter that steps by one on every edge in both directions, including across the 0xFFFFFF/0x000000 rollover. The top stage's `cy_out_n` is low exactly while the 24-bit value sits at its terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| mode | input | 2 | 00 load, 01 up, 10 down, 11 hold |
| preset | input | W | Value loaded in mode 00 |
| cy_in_n | input | 1 | Carry-in, active low |
| la_in_n | input | 1 | Look-ahead carry-in, active low |
| count | output | W | Current count |
| cy_out_n | output | 1 | Registered carry-out, active low |
| la_out_n | output | 1 | Look-ahead carry-out, active low |

## Verification
The properties assume that `mode`, `preset` and both carry inputs are free of X and change only between clock edges. They also assume that no reset pulse falls inside a window where a count or load property has just fired its antecedent. To meet this, the stimulus updates inputs one nanosecond after each rising edge. Before the mid-run reset pulse, it parks the stage in an up mode with carry-in high and look-ahead low, and it holds that reset across a full edge. In the chained runs, every stage except the lowest takes its carry inputs only from the stage below, so the carry inputs of those stages stay within the pulse patterns that chaining produces.

// File: rtl/updn_pkg.sv
package updn_pkg;

   typedef enum logic [1:0] {
      MD_LOAD = 2'b00,
      MD_UP   = 2'b01,
      MD_DOWN = 2'b10,
      MD_HOLD = 2'b11
   } updn_mode_e;

   function automatic logic is_count(updn_mode_e m);
      return (m == MD_UP) || (m == MD_DOWN);
   endfunction

endpackage

// File: rtl/updn_step.sv
// Next-state value of the count register for the selected operation.
module updn_step #(
   parameter int W = 6
) (
   input  updn_pkg::updn_mode_e mode,
   input  logic [W-1:0]         cur,
   input  logic [W-1:0]         preset,
   input  logic                 adv,
   output logic [W-1:0]         nxt
);
   import updn_pkg::*;

   localparam logic [W-1:0] UNIT = W'(1);

   always_comb begin
      unique case (mode)
         MD_LOAD: nxt = preset;
         MD_UP:   nxt = adv ? cur + UNIT : cur;
         MD_DOWN: nxt = adv ? cur - UNIT : cur;
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/updn_mark.sv
// Flags a value that lies OFFSET steps short of the terminal value of the
// current counting direction. Zero outside the two count modes.
module updn_mark #(
   parameter int W      = 6,
   parameter int OFFSET = 0
) (
   input  updn_pkg::updn_mode_e mode,
   input  logic [W-1:0]         val,
   output logic                 hit
);
   import updn_pkg::*;

   localparam logic [W-1:0] ALL1   = '1;
   localparam logic [W-1:0] SHIFT  = W'(OFFSET);
   localparam logic [W-1:0] UP_TGT = ALL1 - SHIFT;
   localparam logic [W-1:0] DN_TGT = SHIFT;

   logic up_hit, dn_hit;

   generate
      if (OFFSET == 0) begin : g_terminal
         assign up_hit = &val;
         assign dn_hit = ~|val;
      end else begin : g_offset
         assign up_hit = (val == UP_TGT);
         assign dn_hit = (val == DN_TGT);
      end
   endgenerate

   always_comb begin
      unique case (mode)
         MD_UP:   hit = up_hit;
         MD_DOWN: hit = dn_hit;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/updn_cascade_stage.sv
module updn_cascade_stage #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [1:0]   mode,
   input  logic [W-1:0] preset,
   input  logic         cy_in_n,
   input  logic         la_in_n,
   output logic [W-1:0] count,
   output logic         cy_out_n,
   output logic         la_out_n
);
   import updn_pkg::*;

   generate
      if (W < 2) begin : g_bad_width
         $error("updn_cascade_stage: W must be at least 2");
      end
   endgenerate

   updn_mode_e   md;
   logic [W-1:0] cnt_q;
   logic [W-1:0] nxt;
   logic         cy_q;
   logic         la_q;
   logic         adv;
   logic         nxt_end;
   logic         cur_end;
   logic         cur_near;

   assign md  = updn_mode_e'(mode);
   assign adv = !cy_in_n && !la_q;

   updn_step #(.W(W)) u_step (
      .mode   (md),
      .cur    (cnt_q),
      .preset (preset),
      .adv    (adv),
      .nxt    (nxt)
   );

   updn_mark #(.W(W), .OFFSET(0)) u_mark_nxt (
      .mode (md),
      .val  (nxt),
      .hit  (nxt_end)
   );

   updn_mark #(.W(W), .OFFSET(0)) u_mark_end (
      .mode (md),
      .val  (cnt_q),
      .hit  (cur_end)
   );

   updn_mark #(.W(W), .OFFSET(1)) u_mark_near (
      .mode (md),
      .val  (cnt_q),
      .hit  (cur_near)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt_q <= '0;
         cy_q  <= 1'b1;
         la_q  <= 1'b1;
      end else begin
         cnt_q <= nxt;
         cy_q  <= !(!la_in_n && nxt_end);
         la_q  <= la_in_n;
      end
   end

   assign count    = cnt_q;
   assign cy_out_n = cy_q;
   assign la_out_n = !(!la_in_n && (cy_in_n ? cur_end : cur_near));
endmodule

// File: rtl/updn_cascade_stage_chk.sv
module updn_cascade_stage_chk #(
   parameter int W = 6
) (
   input logic         clk,
   input logic         rst,
   input logic [1:0]   mode,
   input logic [W-1:0] preset,
   input logic         cy_in_n,
   input logic         la_in_n,
   input logic [W-1:0] count,
   input logic         cy_out_n,
   input logic         la_out_n,
   input logic         la_held
);
   localparam logic [W-1:0] UNIT = W'(1);
   localparam logic [W-1:0] ALL1 = '1;

   p_load_r1: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b00) |=> (count == $past(preset)));

   p_up_r2: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b01 && !cy_in_n && !la_held) |=> (count == $past(count) + UNIT));

   p_down_r3: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b10 && !cy_in_n && !la_held) |=> (count == $past(count) - UNIT));

   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b11) |=> $stable(count));

   p_lahold_r5: assert property (@(posedge clk) disable iff (rst)
      ((mode == 2'b01 || mode == 2'b10) && la_held) |=> $stable(count));

   p_cyterm_r6: assert property (@(posedge clk) disable iff (rst)
      !cy_out_n |-> (count == ALL1 || count == '0));

   p_loadcy_r7: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b00) |=> cy_out_n);

   p_lagate_r8: assert property (@(posedge clk) disable iff (rst)
      !la_out_n |-> ((mode == 2'b01 || mode == 2'b10) && !la_in_n));
endmodule

bind updn_cascade_stage updn_cascade_stage_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mode     (mode),
   .preset   (preset),
   .cy_in_n  (cy_in_n),
   .la_in_n  (la_in_n),
   .count    (count),
   .cy_out_n (cy_out_n),
   .la_out_n (la_out_n),
   .la_held  (la_q)
);

// File: tb/updn_cascade_stage_test.sv
module updn_cascade_stage_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] mode_s = 2'b11;
   logic [5:0] preset_s = '0;
   logic       cy_s = 1'b0;
   logic       la_s = 1'b0;
   logic [5:0] count_o;
   logic       cy_o, la_o;

   int vecs = 0;
   int errs = 0;

   always #2 clk = ~clk;

   updn_cascade_stage #(.W(6)) uut (
      .clk(clk), .rst(rst), .mode(mode_s), .preset(preset_s),
      .cy_in_n(cy_s), .la_in_n(la_s),
      .count(count_o), .cy_out_n(cy_o), .la_out_n(la_o)
   );

   // four-stage chain
   logic [1:0]  ch_mode = 2'b11;
   logic [23:0] ch_pre = '0;
   logic [5:0]  ch_q [4];
   logic        ch_cy [4];
   logic        ch_la [4];

   for (genvar g = 0; g < 4; g++) begin : g_chain
      logic ci, li;
      if (g == 0) begin : g_lsb
         assign ci = 1'b0;
         assign li = 1'b0;
      end else begin : g_up
         assign ci = ch_cy[g-1];
         assign li = ch_la[g-1];
      end
      updn_cascade_stage #(.W(6)) u_st (
         .clk(clk), .rst(rst), .mode(ch_mode), .preset(ch_pre[g*6 +: 6]),
         .cy_in_n(ci), .la_in_n(li),
         .count(ch_q[g]), .cy_out_n(ch_cy[g]), .la_out_n(ch_la[g])
      );
   end

   // bench-side expectation state
   logic [5:0] m_q;
   logic       m_cy, m_lq;

   task automatic chk(input string tag, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] term_of(input logic [1:0] md);
      return (md == 2'b01) ? 6'd63 : 6'd0;
   endfunction

   function automatic logic [5:0] near_of(input logic [1:0] md);
      return (md == 2'b01) ? 6'd62 : 6'd1;
   endfunction

   task automatic step(input logic [1:0] md, input logic [5:0] pd,
                       input logic ci, input logic li);
      logic       adv, cnt, la_exp, held_la;
      logic [5:0] nx;
      string      tag;
      mode_s = md; preset_s = pd; cy_s = ci; la_s = li;
      @(posedge clk); #1;
      adv = !ci && !m_lq;
      held_la = m_lq;
      cnt = (md == 2'b01) || (md == 2'b10);
      case (md)
         2'b00:   nx = pd;
         2'b01:   nx = adv ? m_q + 6'd1 : m_q;
         2'b10:   nx = adv ? m_q - 6'd1 : m_q;
         default: nx = m_q;
      endcase
      m_cy = !(cnt && !li && nx == term_of(md));
      m_lq = li;
      m_q  = nx;
      if (md == 2'b00)      tag = "R1";
      else if (md == 2'b11) tag = "R4";
      else if (ci)          tag = "R4";
      else if (held_la)     tag = "R5";
      else if (md == 2'b01) tag = "R2";
      else                  tag = "R3";
      chk(tag, count_o, m_q);
      chk((md == 2'b00) ? "R7" : "R6", cy_o, m_cy);
      la_exp = !(cnt && !li && (ci ? m_q == term_of(md) : m_q == near_of(md)));
      chk("R8", la_o, la_exp);
   endtask

   task automatic chain_run(input logic [23:0] start, input logic [1:0] md, input int n);
      logic [23:0] exp;
      ch_pre = start; ch_mode = 2'b00;
      @(posedge clk); #1;
      chk("R1", {ch_q[3], ch_q[2], ch_q[1], ch_q[0]}, start);
      exp = start;
      ch_mode = md;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         exp = (md == 2'b01) ? exp + 24'd1 : exp - 24'd1;
         chk("R10", {ch_q[3], ch_q[2], ch_q[1], ch_q[0]}, exp);
         chk("R10", ch_cy[3],
             (exp == ((md == 2'b01) ? 24'hFFFFFF : 24'h000000)) ? 0 : 1);
      end
      ch_mode = 2'b11;
   endtask

   initial begin : watchdog
      #(200000 * 4);
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R9", count_o, 0);
      chk("R9", cy_o, 1);
      m_q = '0; m_cy = 1'b1; m_lq = 1'b1;
      rst = 1'b0;
      // R5/R9: first count edge after reset is held by the look-ahead flop
      step(2'b01, 6'd0, 1'b0, 1'b0);
      // R2, R6, R8: free up count over two wraps
      for (int i = 0; i < 130; i++) step(2'b01, 6'd0, 1'b0, 1'b0);
      // R3: free down count over two wraps
      for (int i = 0; i < 130; i++) step(2'b10, 6'd0, 1'b0, 1'b0);
      // R1, R7: every preset value, then one step each way
      for (int v = 0; v < 64; v++) begin
         step(2'b00, 6'(v), 1'b0, 1'b0);
         step(2'b01, 6'd0, 1'b0, 1'b0);
         step(2'b00, 6'(v), 1'b0, 1'b0);
         step(2'b10, 6'd0, 1'b0, 1'b0);
      end
      // R4: carry-in pauses while counting
      for (int i = 0; i < 100; i++) step(2'b01, 6'd0, (i % 3) == 2, 1'b0);
      for (int i = 0; i < 100; i++) step(2'b10, 6'd0, (i % 4) == 1, 1'b0);
      // R5: look-ahead-in pauses
      for (int i = 0; i < 100; i++) step(2'b01, 6'd0, 1'b0, (i % 5) == 0);
      for (int i = 0; i < 100; i++) step(2'b10, 6'd0, 1'b0, (i % 7) == 3);
      // R4: hold mode with carry inputs moving
      for (int i = 0; i < 20; i++) step(2'b11, 6'(i), i[0], i[1]);
      // R8: look-ahead out with carry-in held high at terminal values
      step(2'b00, 6'd63, 1'b0, 1'b0);
      step(2'b01, 6'd0, 1'b1, 1'b0);
      step(2'b00, 6'd0, 1'b0, 1'b0);
      step(2'b10, 6'd0, 1'b1, 1'b0);
      // R9: asynchronous reset in mid-run
      for (int i = 0; i < 9; i++) step(2'b01, 6'd0, 1'b0, 1'b0);
      step(2'b01, 6'd0, 1'b1, 1'b0);
      step(2'b01, 6'd0, 1'b1, 1'b0);
      rst = 1'b1;
      #1;
      chk("R9", count_o, 0);
      chk("R9", cy_o, 1);
      @(posedge clk); #1;
      m_q = '0; m_cy = 1'b1; m_lq = 1'b1;
      rst = 1'b0;
      step(2'b01, 6'd0, 1'b0, 1'b0);
      chk("R9", count_o, 0);
      step(2'b01, 6'd0, 1'b0, 1'b0);
      // R10: 24-bit chain across both rollovers
      chain_run(24'hFFFFF0, 2'b01, 40);
      chain_run(24'h000010, 2'b10, 40);
      chain_run(24'h03FFF8, 2'b01, 20);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule